// File: doc/BRIEF.md
# Nine-Level Multicarrier PWM Comparator

This block turns one signed reference sample per clock into the eight gate-comparison bits of a nine-level modulator. It builds eight triangular carriers of equal amplitude W = 2^BAND_W and stacks them in adjacent bands, so that together they cover the range from -4W to +4W. Each carrier is compared against the reference. The comparison bits and a signed level index, which is the number of set bits minus four, leave the block through registers. A downstream switch-mapping stage uses these outputs to select one of nine stepped output voltages.

Carriers are grouped in mirrored pairs: the lowest and the highest band, the second-lowest and the second-highest band, and so on. Each pair has its own triangle generator and its own speed setting, so two carrier frequencies can be interleaved across the stack. A run-time mode input chooses how the carriers are phased against each other. A pair picks up a new mode or a new speed only at the start of its own period, so no carrier ever jumps in the middle of a ramp.

Top module: `mlpwm_carrier_cmp`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, `cmp_o` is all zeros, `level_o` is -4, every pair's triangle sits at its lowest point and is set to rise, and each pair loads the current `mode_i` and its speed value.
- R2: Carrier k (k = 0..7, with 0 the lowest) lies in the band from (k-4)*W to (k-3)*W. All eight carriers have the same peak-to-peak amplitude W.
- R3: Pair p (p = 0..3) serves carriers p and 7-p and takes its speed value d from `pair_div_i[p*DIV_W +: DIV_W]`. Its triangle offset moves by one step every d+1 clocks. It rises from 0 to W and then falls back to 0, for a full period of 2*W*(d+1) clocks.
- R4: Bit k of `cmp_o` is 1 exactly when the reference sampled at the previous clock edge is strictly greater than the value of carrier k at that edge. The output latency is one clock.
- R5: Mode code 0 (in-phase) places every carrier at band base plus its pair's offset. Code 3 behaves the same as code 0.
- R6: Mode code 1 (opposed halves) places carriers 0..3, the bands below zero, at band top minus offset, and places carriers 4..7 at band base plus offset.
- R7: Mode code 2 (alternating) places the odd-numbered carriers at band top minus offset and the even-numbered carriers at band base plus offset.
- R8: A pair loads a new mode code and a new speed value only on the clock edge where its offset steps up from 0. At any other time, a change on `mode_i` or on its speed value does not affect that pair's carriers.
- R9: `level_o` is a 4-bit two's-complement number. It equals the count of set bits in `cmp_o` minus 4, and it is registered on the same edge as `cmp_o`.
- R10: `cmp_o` is always a thermometer code: if bit k is set, every lower bit is also set.
- R11: A reference greater than +4W gives all ones and level +4. A reference of -4W or less gives all zeros and level -4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Carrier placement code (0 in-phase, 1 opposed halves, 2 alternating, 3 as 0) |
| pair_div_i | input | NUM_PAIRS*DIV_W (32) | Per-pair step divider; pair p occupies bits p*DIV_W upward |
| sample_i | input | REF_W (10) | Signed reference sample, full scale +/-4W |
| cmp_o | output | NUM_CARRIERS (8) | Registered comparison bits, bit 0 is the lowest band |
| level_o | output | LVL_W (4) | Registered signed level index, -4..+4 |

## Verification
Two functions can fall on the same clock edge: a pair's period boundary and a change of the placement code (or of that pair's speed value). The bench provokes this by tracking its own carrier model. It changes `mode_i` or `pair_div_i` on exactly the cycle in which a pair's step counter is about to expire at the bottom of a rising ramp, and it also makes the same change in the middle of a ramp. A scoreboard then compares the comparison vector and the level on every cycle. This shows that the new placement is applied from the boundary edge onward and that a change in the middle of a ramp is held back until the next boundary.

// File: rtl/mlpwm_pkg.sv
// Shared types for the multicarrier comparator.
// Assumes carriers are numbered from the lowest band upward.
package mlpwm_pkg;

    // Carrier placement scheme selected at run time.
    typedef enum logic [1:0] {
        DISPO_INPHASE   = 2'd0,
        DISPO_OPPOSED   = 2'd1,
        DISPO_ALTERNATE = 2'd2,
        DISPO_SPARE     = 2'd3
    } dispo_e;

    // True when carrier idx runs from the top of its band downward.
    function automatic logic carrier_flipped(input int idx, input int half, input dispo_e m);
        case (m)
            DISPO_OPPOSED:   return (idx < half);
            DISPO_ALTERNATE: return ((idx % 2) == 1);
            default:         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mlpwm_tri_gen.sv
// Triangle offset generator for one mirrored carrier pair.
// A prescaler counts d+1 clocks per step, and the offset ramps 0..2^BAND_W..0.
// The mode and divider are reloaded only at the period boundary
// (the step that leaves 0 going up). Assumes the reset lasts at least one clock.
module mlpwm_tri_gen
    import mlpwm_pkg::*;
#(
    parameter int BAND_W = 6,
    parameter int DIV_W  = 8,
    localparam int TRI_W = BAND_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  dispo_e           mode_i,
    output logic [TRI_W-1:0] tri_o,
    output dispo_e           mode_o
);

    localparam int SPAN = 1 << BAND_W;
    localparam logic [TRI_W-1:0] TOP_V  = TRI_W'(SPAN);
    localparam logic [TRI_W-1:0] LAST_V = TRI_W'(SPAN - 1);
    localparam logic [TRI_W-1:0] ONE_V  = TRI_W'(1);

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [TRI_W-1:0] tri_q;
    logic             rise_q;
    dispo_e           mode_q;
    logic             tick;
    logic             boundary;
    logic             armed_q;

    assign tick     = (pre_q == div_q);
    assign boundary = tick && rise_q && (tri_q == '0);

    // Prescaler: counts clocks between offset steps.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + DIV_W'(1);
    end

    // Offset ramp: one step per tick, turning at the top and at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tri_q  <= '0;
            rise_q <= 1'b1;
        end else if (tick) begin
            if (rise_q) begin
                tri_q <= tri_q + ONE_V;
                if (tri_q == LAST_V) rise_q <= 1'b0;
            end else begin
                tri_q <= tri_q - ONE_V;
                if (tri_q == ONE_V) rise_q <= 1'b1;
            end
        end
    end

    // Settings latch: takes the mode and divider at reset or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || boundary) begin
            mode_q <= mode_i;
            div_q  <= div_i;
        end
    end

    // Assertion arming: blocks $past until one cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign tri_o  = tri_q;
    assign mode_o = mode_q;

    // R2
    tri_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        tri_q <= TOP_V);

    // R3
    tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (tri_q == $past(tri_q)) || (tri_q == $past(tri_q) + ONE_V) || (tri_q == $past(tri_q) - ONE_V));

    // R3
    turn_top_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $fell(rise_q) |-> (tri_q == TOP_V));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$stable(mode_q) |-> (tri_q == ONE_V && rise_q));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$stable(div_q) |-> (tri_q == ONE_V && rise_q));

endmodule

// File: rtl/mlpwm_level_enc.sv
// Level encoder: counts the set comparison bits and removes the mid-stack offset.
// Assumes an even number of carriers, so that the index is symmetric about zero.
module mlpwm_level_enc #(
    parameter int NUM_CARRIERS = 8,
    localparam int LVL_W = $clog2(NUM_CARRIERS) + 1
) (
    input  logic [NUM_CARRIERS-1:0] hit_i,
    output logic signed [LVL_W-1:0] level_o
);

    localparam int HALF = NUM_CARRIERS / 2;

    logic [LVL_W-1:0] ones;

    // Population count of the comparison vector.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_CARRIERS; i++) begin
            ones = ones + LVL_W'(hit_i[i]);
        end
    end

    assign level_o = ones - LVL_W'(HALF);

endmodule

// File: rtl/mlpwm_band_cmp.sv
// Band comparator: builds each carrier value from its band base, its pair's
// offset and its placement, compares it strictly against the reference, and
// registers the bits with the level index. Carrier k uses pair k or N-1-k.
module mlpwm_band_cmp
    import mlpwm_pkg::*;
#(
    parameter int NUM_CARRIERS = 8,
    parameter int BAND_W       = 6,
    localparam int NUM_PAIRS   = NUM_CARRIERS / 2,
    localparam int TRI_W       = BAND_W + 1,
    localparam int LVL_W       = $clog2(NUM_CARRIERS) + 1,
    localparam int REF_W       = BAND_W + LVL_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic signed [REF_W-1:0]             sample_i,
    input  logic [NUM_PAIRS-1:0][TRI_W-1:0]     tri_i,
    input  dispo_e [NUM_PAIRS-1:0]              mode_i,
    output logic [NUM_CARRIERS-1:0]             cmp_o,
    output logic signed [LVL_W-1:0]             level_o
);

    localparam int HALF  = NUM_CARRIERS / 2;
    localparam int SPAN  = 1 << BAND_W;
    localparam int CAR_W = REF_W + 1;
    localparam logic signed [CAR_W-1:0] TOP_V = CAR_W'(HALF * SPAN);
    localparam logic signed [CAR_W-1:0] BOT_V = CAR_W'(-HALF * SPAN);
    localparam logic [NUM_CARRIERS-1:0] ONE_V = NUM_CARRIERS'(1);

    logic signed [CAR_W-1:0]   sample_ext;
    logic [NUM_CARRIERS-1:0]   hit;
    logic signed [LVL_W-1:0]   lvl_d;
    logic [NUM_CARRIERS-1:0]   cmp_q;
    logic signed [LVL_W-1:0]   level_q;
    logic                      armed_q;

    assign sample_ext = {sample_i[REF_W-1], sample_i};

    for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_car
        localparam int PAIR = (k < HALF) ? k : (NUM_CARRIERS - 1 - k);
        localparam int BASE = (k - HALF) * SPAN;
        logic [TRI_W-1:0]        off;
        logic signed [CAR_W-1:0] car;
        assign off    = carrier_flipped(k, HALF, mode_i[PAIR]) ? (TRI_W'(SPAN) - tri_i[PAIR]) : tri_i[PAIR];
        assign car    = CAR_W'(BASE) + CAR_W'(off);
        assign hit[k] = (sample_ext > car);
    end

    mlpwm_level_enc #(.NUM_CARRIERS(NUM_CARRIERS)) u_lvl (
        .hit_i   (hit),
        .level_o (lvl_d)
    );

    // Output register: the comparison bits and the level move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            level_q <= LVL_W'(-HALF);
        end else begin
            cmp_q   <= hit;
            level_q <= lvl_d;
        end
    end

    // Assertion arming: blocks $past until one cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign cmp_o   = cmp_q;
    assign level_o = level_q;

    // R10
    thermo_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (cmp_q & (cmp_q + ONE_V)) == '0);

    // R9
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (level_q >= -HALF) && (level_q <= HALF));

    // R11
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(sample_ext > TOP_V) |-> (cmp_q == '1 && level_q == HALF));

    // R11
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(sample_ext <= BOT_V) |-> (cmp_q == '0 && level_q == -HALF));

endmodule

// File: rtl/mlpwm_carrier_cmp.sv
// Top of the nine-level multicarrier comparator.
// It holds one triangle generator per mirrored carrier pair and one shared band
// comparator. Assumes NUM_CARRIERS is even and the reference is a two's-complement
// sample scaled so that +/-HALF*2^BAND_W is full scale.
module mlpwm_carrier_cmp
    import mlpwm_pkg::*;
#(
    parameter int NUM_CARRIERS = 8,
    parameter int BAND_W       = 6,
    parameter int DIV_W        = 8,
    localparam int NUM_PAIRS   = NUM_CARRIERS / 2,
    localparam int LVL_W       = $clog2(NUM_CARRIERS) + 1,
    localparam int REF_W       = BAND_W + LVL_W,
    localparam int TRI_W       = BAND_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode_i,
    input  logic [NUM_PAIRS*DIV_W-1:0]    pair_div_i,
    input  logic signed [REF_W-1:0]       sample_i,
    output logic [NUM_CARRIERS-1:0]       cmp_o,
    output logic signed [LVL_W-1:0]       level_o
);

    dispo_e                          mode_sel;
    logic [NUM_PAIRS-1:0][TRI_W-1:0] tri_bus;
    dispo_e [NUM_PAIRS-1:0]          mode_bus;

    assign mode_sel = dispo_e'(mode_i);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        mlpwm_tri_gen #(.BAND_W(BAND_W), .DIV_W(DIV_W)) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_i  (pair_div_i[p*DIV_W +: DIV_W]),
            .mode_i (mode_sel),
            .tri_o  (tri_bus[p]),
            .mode_o (mode_bus[p])
        );
    end

    mlpwm_band_cmp #(.NUM_CARRIERS(NUM_CARRIERS), .BAND_W(BAND_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .tri_i    (tri_bus),
        .mode_i   (mode_bus),
        .cmp_o    (cmp_o),
        .level_o  (level_o)
    );

endmodule

// File: tb/sim_mlpwm_carrier_cmp.sv
`timescale 1ns/1ps
// Scoreboard bench: the drive task applies one cycle of stimulus, predicts that
// cycle's registered outputs from its own carrier model and queues them; the
// monitor compares shortly after each rising edge.
module sim_mlpwm_carrier_cmp;

    localparam int NC = 8, NP = 4, BW = 6, DW = 8, W = 64, HALF = 4;
    localparam int REF_W = 10, LVL_W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic [1:0]               mode_i = 2'd0;
    logic [NP*DW-1:0]         pair_div_i = '0;
    logic signed [REF_W-1:0]  sample_i = '0;
    logic [NC-1:0]            cmp_o;
    logic signed [LVL_W-1:0]  level_o;

    mlpwm_carrier_cmp u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pair_div_i(pair_div_i),
        .sample_i(sample_i), .cmp_o(cmp_o), .level_o(level_o)
    );

    typedef struct packed {
        logic [NC-1:0]    cmp;
        logic [LVL_W-1:0] lvl;
        logic [31:0]      tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] tag = "R1  ";
    logic [NP*DW-1:0] div_v = {8'd3, 8'd2, 8'd3, 8'd2};

    int m_cnt[NP], m_tri[NP], m_div[NP], m_mode[NP];
    bit m_up[NP];
    int n_checks = 0, n_fail = 0, wd = 0;
    bit done = 1'b0;

    function automatic bit flipped(int k, int md);
        if (md == 1) return (k < HALF);
        if (md == 2) return ((k % 2) == 1);
        return 1'b0;
    endfunction

    // One clock of stimulus with prediction (R2..R8 model).
    task automatic step(input bit r, input int md, input int rv);
        exp_t e;
        int   ones;
        @(negedge clk);
        rst_n = r; mode_i = md[1:0]; pair_div_i = div_v; sample_i = REF_W'(rv);
        ones = 0;
        e.cmp = '0;
        if (!r) begin
            e.lvl = LVL_W'(-HALF);
        end else begin
            for (int k = 0; k < NC; k++) begin
                int p, off, car;
                p   = (k < HALF) ? k : NC - 1 - k;
                off = flipped(k, m_mode[p]) ? W - m_tri[p] : m_tri[p];
                car = (k - HALF) * W + off;
                e.cmp[k] = (rv > car);
                if (rv > car) ones++;
            end
            e.lvl = LVL_W'(ones - HALF);
        end
        e.tag = tag;
        sb_q.push_back(e);
        for (int p = 0; p < NP; p++) begin
            int dv;
            bit tk;
            dv = int'(div_v[p*DW +: DW]);
            if (!r) begin
                m_cnt[p] = 0; m_tri[p] = 0; m_up[p] = 1'b1; m_mode[p] = md; m_div[p] = dv;
            end else begin
                tk = (m_cnt[p] == m_div[p]);
                if (tk && m_tri[p] == 0 && m_up[p]) begin
                    m_mode[p] = md; m_div[p] = dv;
                end
                if (tk) begin
                    m_cnt[p] = 0;
                    if (m_up[p]) begin
                        m_tri[p]++;
                        if (m_tri[p] == W) m_up[p] = 1'b0;
                    end else begin
                        m_tri[p]--;
                        if (m_tri[p] == 0) m_up[p] = 1'b1;
                    end
                end else begin
                    m_cnt[p]++;
                end
            end
        end
    endtask

    // Monitor: pops one prediction per edge, 1 ns after it.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0 && !done) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (cmp_o !== e.cmp) begin
                n_fail++;
                $display("FAIL %s cmp_o=%b expected %b", e.tag, cmp_o, e.cmp);
            end
            n_checks++;
            if (level_o !== e.lvl) begin
                n_fail++;
                $display("FAIL R9 level_o=%0d expected %0d", level_o, $signed(e.lvl));
            end
            n_checks++;
            if ((cmp_o & (cmp_o + 8'd1)) != 8'd0) begin
                n_fail++;
                $display("FAIL R10 cmp_o=%b expected thermometer code", cmp_o);
            end
        end
    end

    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog cycles=%0d expected below 150000", wd);
            report();
        end
    end

    task automatic sine_run(input int md, input real ma, input int cycles);
        for (int n = 0; n < cycles; n++) begin
            step(1'b1, md, $rtoi(ma * 4.0 * W * $sin(6.283185307 * n / 2000.0)));
        end
    endtask

    initial begin
        int md_now;
        // R1: reset state and loading.
        tag = "R1  ";
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0);

        // R2: slow ramp across every band, in-phase, checks band placement.
        tag = "R2  ";
        for (int v = -4 * W - 3; v <= 4 * W + 3; v++) begin
            step(1'b1, 0, v); step(1'b1, 0, v);
        end

        // R4: sine at index 0.8 and 1.0, exact band edges included.
        tag = "R4  ";
        sine_run(0, 0.8, 2000);
        sine_run(0, 1.0, 2000);
        for (int j = -4; j <= 4; j++)
            for (int i = 0; i < 40; i++) step(1'b1, 0, j * W);

        // R3: swap the pair speeds; the mirrored pairs run at 4:3 step rates.
        tag = "R3  ";
        div_v = {8'd2, 8'd3, 8'd2, 8'd3};
        sine_run(0, 0.9, 2500);

        // R5: code 3 behaves as in-phase.
        tag = "R5  ";
        sine_run(3, 0.85, 2000);

        // R6: opposed halves.
        tag = "R6  ";
        sine_run(1, 0.85, 2000);

        // R7: alternating placement.
        tag = "R7  ";
        sine_run(2, 0.85, 2000);

        // R8: mode change timed onto pair 0's boundary, then in mid-ramp.
        tag = "R8  ";
        md_now = 2;
        for (int t = 0; t < 3; t++) begin
            for (int g = 0; g < 2000; g++) begin
                if (m_tri[0] == 0 && m_up[0] && m_cnt[0] == m_div[0]) break;
                step(1'b1, md_now, 100);
            end
            md_now = (md_now + 1) % 3;
            for (int i = 0; i < 300; i++) step(1'b1, md_now, 40 - i / 4);
            for (int g = 0; g < 2000; g++) begin
                if (m_tri[0] == W / 2) break;
                step(1'b1, md_now, -60);
            end
            md_now = (md_now + 1) % 3;
            div_v = (t % 2 == 0) ? {8'd1, 8'd3, 8'd1, 8'd3} : {8'd3, 8'd2, 8'd3, 8'd2};
            for (int i = 0; i < 700; i++) step(1'b1, md_now, -100 + i / 4);
        end

        // R11: saturation at and beyond full scale.
        tag = "R11 ";
        for (int i = 0; i < 300; i++) step(1'b1, 1, 4 * W + 1);
        for (int i = 0; i < 300; i++) step(1'b1, 2, 300);
        for (int i = 0; i < 300; i++) step(1'b1, 0, -4 * W);
        for (int i = 0; i < 300; i++) step(1'b1, 1, -300);
        for (int i = 0; i < 300; i++) step(1'b1, 2, 4 * W);

        // R1: reset in mid-run returns to the reset state.
        tag = "R1  ";
        for (int i = 0; i < 3; i++) step(1'b0, 1, 200);
        tag = "R4  ";
        sine_run(1, 1.0, 600);

        step(1'b1, 0, 0);
        @(posedge clk); #2;
        report();
    end

endmodule